// File: doc/BRIEF.md
# USB Pipe Control Register Bank

This block holds the per-pipe control state of a USB host/function controller. Pipe 0 is the default control pipe. Pipes 1 to 9 are general pipes. Software reaches every pipe through one synchronous register port. Each pipe has two registers:

- a control word, which holds the response mode, the data-toggle controls, auto buffer clear, busy, the counter controls, a lock-error flag and a modification request;
- a count word, which holds the transaction counter.

The protocol engine supplies three per-pipe pulses or levels: a busy level, a successful-transaction pulse and a completed-transaction pulse. The bank drives the state the engine needs back to it.

The bank guards the pipe's setup while the pipe is live. While a pipe's response mode is BUF (communication enabled), writes to its toggle strobes, auto buffer clear, counter controls and count word are discarded, and a sticky error flag records the attempt. The intended procedure is:

1. Raise the modification request.
2. Return the pipe to NAK.
3. Reprogram the locked fields.

Top module: `usb_pipe_ctl_bank`

## Requirements
- R1: After reset every pipe is in NAK, with toggle 0, count 0 and all enables and flags 0. Every register then reads 0, except that the busy bit mirrors its input.
- R2: Address bits [4:1] select the pipe and bit 0 selects the word (0 = control, 1 = count). Control bit 0 is the response mode (1 = BUF, 0 = NAK). It is writable at any time and appears on `pipe_buf`. It changes only on a write.
- R3: Control bit 2 (toggle clear) forces the toggle to 0, and control bit 1 (toggle set) forces it to 1. When both are written together, the clear wins. Both bits read back as 0. Control bit 3 reads the current toggle.
- R4: While a pipe is in BUF, each `eng_txn_ok` pulse inverts its toggle. While the pipe is in NAK, the pulse has no effect.
- R5: While the mode is BUF, the following writes are discarded and set the sticky error (control bit 9):
  - a toggle strobe;
  - a change of auto buffer clear;
  - a change of counter enable;
  - a counter clear strobe;
  - any count-word write on a counter pipe.

  Writing 1 to bit 9 clears the error, unless the same write sets it again.
- R6: Auto buffer clear (control bit 4) is held only on pipes 1 to 9. On pipe 0 it reads 0 and its output stays 0.
- R7: The counter enable (bit 6), the counter clear (bit 7), the done flag (bit 8) and the count word exist only on pipes 1 to 5. On other pipes they read 0.
- R8: While enabled, the count decrements on each `eng_txn_done` pulse and stops at 0. The step from 1 to 0 sets the done flag (bit 8, `pipe_cnt_done`).
- R9: Writing the count word (bits [7:0]) loads both the programmed and the current count and clears done. The clear strobe reloads the current count from the programmed one and clears done. The clear strobe wins over a decrement in the same cycle.
- R10: Control bit 5 reads the live `eng_busy` level of the pipe.
- R11: Control bit 10 (modification request) is read/write. A control write that moves the pipe from BUF to NAK clears it.
- R12: Pipe indices 10 to 15 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | {pipe index, word select} |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| eng_busy | input | 10 | Per-pipe busy level from the engine |
| eng_txn_ok | input | 10 | Per-pipe successful-transaction pulse |
| eng_txn_done | input | 10 | Per-pipe completed-transaction pulse |
| pipe_buf | output | 10 | Per-pipe response mode is BUF |
| pipe_toggle | output | 10 | Per-pipe data toggle |
| pipe_auto_clr | output | 10 | Per-pipe auto buffer clear |
| pipe_cnt_done | output | 10 | Per-pipe counter done flag |
| pipe_lock_err | output | 10 | Per-pipe sticky lock error |

## Verification
Two pairs of events can fall in the same cycle, and the bench provokes both:

- **Counter clear and decrement.** A counter clear strobe and a completed-transaction pulse can hit the same pipe on the same edge. The bench drives them together on a pipe whose count is mid-run, and also lets random traffic produce the overlap. The reload value must win, with no decrement.
- **Toggle set and clear.** Both strobes can arrive in one write. Random control words produce the overlap often. The toggle must land at 0.

In both cases the bench model judges the result from the priority rules alone.

// File: rtl/usb_pipe_pkg.sv
package usb_pipe_pkg;
  localparam int REG_W = 16;

  localparam int F_PID  = 0;
  localparam int F_SET  = 1;
  localparam int F_CLR  = 2;
  localparam int F_TOG  = 3;
  localparam int F_ABC  = 4;
  localparam int F_BUSY = 5;
  localparam int F_CEN  = 6;
  localparam int F_CCLR = 7;
  localparam int F_DONE = 8;
  localparam int F_ERR  = 9;
  localparam int F_REQ  = 10;

  // Toggle priority: clear, then set, then engine flip.
  function automatic logic next_toggle(input logic cur, input logic set_s,
                                       input logic clr_s, input logic flip);
    if (clr_s)      return 1'b0;
    else if (set_s) return 1'b1;
    else if (flip)  return ~cur;
    else            return cur;
  endfunction

  // True when a write touches a field that is frozen while the pipe is live.
  function automatic logic lock_hit_f(input logic is_buf, input logic wr_ctl,
                                      input logic wr_cnt, input logic has_abc,
                                      input logic has_cnt, input logic [REG_W-1:0] wd,
                                      input logic abc_now, input logic en_now);
    logic ctl_bad;
    ctl_bad = wd[F_SET] | wd[F_CLR]
            | (has_abc & (wd[F_ABC] != abc_now))
            | (has_cnt & ((wd[F_CEN] != en_now) | wd[F_CCLR]));
    return is_buf & ((wr_ctl & ctl_bad) | (wr_cnt & has_cnt));
  endfunction

  // Request bit after a control write: cleared by a BUF to NAK move.
  function automatic logic next_req(input logic was_buf, input logic [REG_W-1:0] wd);
    return (was_buf & ~wd[F_PID]) ? 1'b0 : wd[F_REQ];
  endfunction
endpackage

// File: rtl/usb_pipe_slot.sv
module usb_pipe_slot
  import usb_pipe_pkg::*;
#(
  parameter bit HAS_ABC = 1'b1,
  parameter bit HAS_CNT = 1'b1,
  parameter int CNT_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctl,
  input  logic             wr_cnt,
  input  logic [REG_W-1:0] wdata,
  input  logic             busy_in,
  input  logic             txn_ok,
  input  logic             txn_done,
  output logic [REG_W-1:0] ctl_rd,
  output logic [REG_W-1:0] cnt_rd,
  output logic             buf_o,
  output logic             tog_o,
  output logic             abc_o,
  output logic             done_o,
  output logic             err_o,
  output logic             lock_hit_o
);
  logic pid_q, tog_q, abc_q, en_q, done_q, err_q, req_q;
  logic open_w, set_s, clr_s, flip_s, lock_hit;
  logic [CNT_W-1:0] cur_q;
  logic unused_in;

  assign unused_in = ^{wdata, txn_done};
  assign open_w    = ~pid_q;
  assign set_s     = wr_ctl & open_w & wdata[F_SET];
  assign clr_s     = wr_ctl & open_w & wdata[F_CLR];
  assign flip_s    = txn_ok & pid_q;
  assign lock_hit  = lock_hit_f(pid_q, wr_ctl, wr_cnt, HAS_ABC, HAS_CNT,
                                wdata, abc_q, en_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pid_q <= 1'b0;
      tog_q <= 1'b0;
      err_q <= 1'b0;
      req_q <= 1'b0;
    end else begin
      if (wr_ctl) begin
        pid_q <= wdata[F_PID];
        req_q <= next_req(pid_q, wdata);
      end
      tog_q <= next_toggle(tog_q, set_s, clr_s, flip_s);
      if (lock_hit)                    err_q <= 1'b1;
      else if (wr_ctl && wdata[F_ERR]) err_q <= 1'b0;
    end
  end

  generate
    if (HAS_ABC) begin : g_abc
      always_ff @(posedge clk) begin
        if (!rst_n)                abc_q <= 1'b0;
        else if (wr_ctl && open_w) abc_q <= wdata[F_ABC];
      end
    end else begin : g_no_abc
      assign abc_q = 1'b0;
    end

    if (HAS_CNT) begin : g_cnt
      logic [CNT_W-1:0] prog_q;
      logic load_s, reload_s, dec_s;

      function automatic logic [CNT_W-1:0] cnt_next(
          input logic load, input logic [CNT_W-1:0] ld_val,
          input logic reload, input logic [CNT_W-1:0] prog,
          input logic dec, input logic [CNT_W-1:0] cur);
        if (load)        return ld_val;
        else if (reload) return prog;
        else if (dec)    return cur - CNT_W'(1);
        else             return cur;
      endfunction

      assign load_s   = wr_cnt & open_w;
      assign reload_s = wr_ctl & open_w & wdata[F_CCLR];
      assign dec_s    = en_q & txn_done & (cur_q != '0);

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          en_q   <= 1'b0;
          prog_q <= '0;
          cur_q  <= '0;
          done_q <= 1'b0;
        end else begin
          if (wr_ctl && open_w) en_q <= wdata[F_CEN];
          if (load_s) prog_q <= wdata[CNT_W-1:0];
          cur_q <= cnt_next(load_s, wdata[CNT_W-1:0], reload_s, prog_q, dec_s, cur_q);
          if (load_s || reload_s)                done_q <= 1'b0;
          else if (dec_s && cur_q == CNT_W'(1))  done_q <= 1'b1;
        end
      end
    end else begin : g_no_cnt
      assign en_q   = 1'b0;
      assign cur_q  = '0;
      assign done_q = 1'b0;
    end
  endgenerate

  always_comb begin
    ctl_rd         = '0;
    ctl_rd[F_PID]  = pid_q;
    ctl_rd[F_TOG]  = tog_q;
    ctl_rd[F_ABC]  = abc_q;
    ctl_rd[F_BUSY] = busy_in;
    ctl_rd[F_CEN]  = en_q;
    ctl_rd[F_DONE] = done_q;
    ctl_rd[F_ERR]  = err_q;
    ctl_rd[F_REQ]  = req_q;
    cnt_rd         = '0;
    cnt_rd[CNT_W-1:0] = cur_q;
  end

  assign buf_o      = pid_q;
  assign tog_o      = tog_q;
  assign abc_o      = abc_q;
  assign done_o     = done_q;
  assign err_o      = err_q;
  assign lock_hit_o = lock_hit;
endmodule

// File: rtl/usb_pipe_rdmux.sv
module usb_pipe_rdmux
  import usb_pipe_pkg::*;
#(
  parameter int NUM_PIPES = 10,
  parameter int PIPE_W    = 4
) (
  input  logic [PIPE_W-1:0] pipe_idx,
  input  logic              word_sel,
  input  logic [REG_W-1:0]  ctl_rd [NUM_PIPES],
  input  logic [REG_W-1:0]  cnt_rd [NUM_PIPES],
  output logic [REG_W-1:0]  rdata
);
  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_PIPES; i++) begin
      if (pipe_idx == PIPE_W'(i)) rdata = word_sel ? cnt_rd[i] : ctl_rd[i];
    end
  end
endmodule

// File: rtl/usb_pipe_ctl_bank.sv
module usb_pipe_ctl_bank
  import usb_pipe_pkg::*;
#(
  parameter int NUM_PIPES = 10,
  parameter int ABC_FIRST = 1,
  parameter int CNT_LAST  = 5,
  parameter int CNT_W     = 8,
  localparam int PIPE_W   = $clog2(NUM_PIPES),
  localparam int AW       = PIPE_W + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [AW-1:0]        reg_addr,
  input  logic [REG_W-1:0]     reg_wdata,
  output logic [REG_W-1:0]     reg_rdata,
  input  logic [NUM_PIPES-1:0] eng_busy,
  input  logic [NUM_PIPES-1:0] eng_txn_ok,
  input  logic [NUM_PIPES-1:0] eng_txn_done,
  output logic [NUM_PIPES-1:0] pipe_buf,
  output logic [NUM_PIPES-1:0] pipe_toggle,
  output logic [NUM_PIPES-1:0] pipe_auto_clr,
  output logic [NUM_PIPES-1:0] pipe_cnt_done,
  output logic [NUM_PIPES-1:0] pipe_lock_err
);
  logic [PIPE_W-1:0]    pipe_idx;
  logic                 word_sel;
  logic [REG_W-1:0]     ctl_rd [NUM_PIPES];
  logic [REG_W-1:0]     cnt_rd [NUM_PIPES];
  logic [NUM_PIPES-1:0] lock_hit;

  assign pipe_idx = reg_addr[AW-1:1];
  assign word_sel = reg_addr[0];

  generate
    for (genvar i = 0; i < NUM_PIPES; i++) begin : g_pipe
      localparam bit HAS_ABC = (i >= ABC_FIRST);
      localparam bit HAS_CNT = (i >= 1) && (i <= CNT_LAST);
      logic hit;
      assign hit = reg_wr & (pipe_idx == PIPE_W'(i));

      usb_pipe_slot #(.HAS_ABC(HAS_ABC), .HAS_CNT(HAS_CNT), .CNT_W(CNT_W)) u_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_ctl     (hit & ~word_sel),
        .wr_cnt     (hit & word_sel),
        .wdata      (reg_wdata),
        .busy_in    (eng_busy[i]),
        .txn_ok     (eng_txn_ok[i]),
        .txn_done   (eng_txn_done[i]),
        .ctl_rd     (ctl_rd[i]),
        .cnt_rd     (cnt_rd[i]),
        .buf_o      (pipe_buf[i]),
        .tog_o      (pipe_toggle[i]),
        .abc_o      (pipe_auto_clr[i]),
        .done_o     (pipe_cnt_done[i]),
        .err_o      (pipe_lock_err[i]),
        .lock_hit_o (lock_hit[i])
      );
    end
  endgenerate

  usb_pipe_rdmux #(.NUM_PIPES(NUM_PIPES), .PIPE_W(PIPE_W)) u_rdmux (
    .pipe_idx (pipe_idx),
    .word_sel (word_sel),
    .ctl_rd   (ctl_rd),
    .cnt_rd   (cnt_rd),
    .rdata    (reg_rdata)
  );
endmodule

// File: rtl/usb_pipe_ctl_chk.sv
module usb_pipe_ctl_chk #(
  parameter int NUM_PIPES = 10,
  parameter int CNT_LAST  = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reg_wr,
  input logic [NUM_PIPES-1:0] pipe_buf,
  input logic [NUM_PIPES-1:0] pipe_toggle,
  input logic [NUM_PIPES-1:0] pipe_auto_clr,
  input logic [NUM_PIPES-1:0] pipe_cnt_done,
  input logic [NUM_PIPES-1:0] pipe_lock_err,
  input logic [NUM_PIPES-1:0] eng_txn_ok,
  input logic [NUM_PIPES-1:0] eng_txn_done,
  input logic [NUM_PIPES-1:0] lock_hit
);
  assert_mode_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> $stable(pipe_buf));

  generate
    for (genvar i = 0; i < NUM_PIPES; i++) begin : g_chk
      assert_tog_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_buf[i] && eng_txn_ok[i] && !reg_wr) |=> (pipe_toggle[i] != $past(pipe_toggle[i])));
      assert_tog_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_buf[i] && !reg_wr) |=> $stable(pipe_toggle[i]));
      assert_lock_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lock_hit[i] |=> pipe_lock_err[i]);
      assert_abc_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_buf[i] |=> $stable(pipe_auto_clr[i]));
      assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_lock_err[i] && !reg_wr) |=> pipe_lock_err[i]);
      assert_done_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pipe_cnt_done[i]) |-> $past(eng_txn_done[i]));
      if (i == 0 || i > CNT_LAST) begin : g_nocnt
        assert_no_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
          eng_txn_done[i] |=> !pipe_cnt_done[i]);
      end
    end
  endgenerate
endmodule

bind usb_pipe_ctl_bank usb_pipe_ctl_chk #(.NUM_PIPES(NUM_PIPES), .CNT_LAST(CNT_LAST)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .reg_wr        (reg_wr),
  .pipe_buf      (pipe_buf),
  .pipe_toggle   (pipe_toggle),
  .pipe_auto_clr (pipe_auto_clr),
  .pipe_cnt_done (pipe_cnt_done),
  .pipe_lock_err (pipe_lock_err),
  .eng_txn_ok    (eng_txn_ok),
  .eng_txn_done  (eng_txn_done),
  .lock_hit      (lock_hit)
);

// File: tb/sim_usb_pipe_ctl_bank.sv
`timescale 1ns/1ps
module sim_usb_pipe_ctl_bank;
  localparam int NP = 10;

  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic [NP-1:0] eng_busy = '0, eng_txn_ok = '0, eng_txn_done = '0;
  logic [NP-1:0] pipe_buf, pipe_toggle, pipe_auto_clr, pipe_cnt_done, pipe_lock_err;

  always #2 clk = ~clk;

  usb_pipe_ctl_bank u0 (.*);

  int checks = 0, failures = 0;
  bit finished = 0;

  bit m_pid[NP], m_tog[NP], m_abc[NP], m_en[NP], m_done[NP], m_err[NP], m_req[NP];
  logic [7:0] m_prog[NP], m_cur[NP];
  bit n_pid[NP], n_tog[NP], n_abc[NP], n_en[NP], n_done[NP], n_err[NP], n_req[NP];
  logic [7:0] n_prog[NP], n_cur[NP];

  function automatic bit has_abc(int i); return i >= 1; endfunction
  function automatic bit has_cnt(int i); return i >= 1 && i <= 5; endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NP; i++) begin
      m_pid[i] = 0; m_tog[i] = 0; m_abc[i] = 0; m_en[i] = 0; m_done[i] = 0;
      m_err[i] = 0; m_req[i] = 0; m_prog[i] = 0; m_cur[i] = 0;
    end
  endtask

  task automatic model_next();
    for (int i = 0; i < NP; i++) begin
      bit wc, wn, live, bad, lk, dec, rel, ld;
      logic [15:0] d;
      d  = reg_wdata;
      wc = reg_wr && reg_addr[4:1] == 4'(i) && !reg_addr[0];
      wn = reg_wr && reg_addr[4:1] == 4'(i) && reg_addr[0];
      live = m_pid[i];
      bad = d[1] || d[2] || (has_abc(i) && d[4] != m_abc[i])
            || (has_cnt(i) && (d[6] != m_en[i] || d[7]));
      lk = live && ((wc && bad) || (wn && has_cnt(i)));
      n_pid[i] = wc ? d[0] : m_pid[i];
      n_req[i] = wc ? ((live && !d[0]) ? 1'b0 : d[10]) : m_req[i];
      if (wc && !live && d[2])      n_tog[i] = 0;
      else if (wc && !live && d[1]) n_tog[i] = 1;
      else if (eng_txn_ok[i] && live) n_tog[i] = !m_tog[i];
      else n_tog[i] = m_tog[i];
      n_err[i] = lk ? 1'b1 : ((wc && d[9]) ? 1'b0 : m_err[i]);
      n_abc[i] = (has_abc(i) && wc && !live) ? d[4] : m_abc[i];
      n_en[i]  = (has_cnt(i) && wc && !live) ? d[6] : m_en[i];
      ld  = has_cnt(i) && wn && !live;
      rel = has_cnt(i) && wc && !live && d[7];
      dec = m_en[i] && eng_txn_done[i] && m_cur[i] != 0;
      n_prog[i] = ld ? d[7:0] : m_prog[i];
      n_cur[i]  = ld ? d[7:0] : rel ? m_prog[i] : dec ? m_cur[i] - 8'd1 : m_cur[i];
      n_done[i] = (ld || rel) ? 1'b0 : (dec && m_cur[i] == 8'd1) ? 1'b1 : m_done[i];
    end
  endtask

  task automatic model_commit();
    for (int i = 0; i < NP; i++) begin
      m_pid[i] = n_pid[i]; m_tog[i] = n_tog[i]; m_abc[i] = n_abc[i]; m_en[i] = n_en[i];
      m_done[i] = n_done[i]; m_err[i] = n_err[i]; m_req[i] = n_req[i];
      m_prog[i] = n_prog[i]; m_cur[i] = n_cur[i];
    end
  endtask

  function automatic logic [15:0] model_read(logic [4:0] a);
    int p = int'(a[4:1]);
    logic [15:0] r = '0;
    if (p >= NP) return '0;
    if (a[0]) begin
      r[7:0] = m_cur[p];
    end else begin
      r[0] = m_pid[p]; r[3] = m_tog[p]; r[4] = m_abc[p]; r[5] = eng_busy[p];
      r[6] = m_en[p]; r[8] = m_done[p]; r[9] = m_err[p]; r[10] = m_req[p];
    end
    return r;
  endfunction

  task automatic check_outputs();
    for (int i = 0; i < NP; i++) begin
      chk($sformatf("R2 mode pipe%0d", i),   16'(pipe_buf[i]),      16'(m_pid[i]));
      chk($sformatf("R4 toggle pipe%0d", i), 16'(pipe_toggle[i]),   16'(m_tog[i]));
      chk($sformatf("R6 autoclr pipe%0d", i),16'(pipe_auto_clr[i]), 16'(m_abc[i]));
      chk($sformatf("R8 done pipe%0d", i),   16'(pipe_cnt_done[i]), 16'(m_done[i]));
      chk($sformatf("R5 err pipe%0d", i),    16'(pipe_lock_err[i]), 16'(m_err[i]));
    end
  endtask

  task automatic step(bit wr, logic [4:0] a, logic [15:0] d,
                      logic [NP-1:0] ok, logic [NP-1:0] dn);
    reg_wr = wr; reg_addr = a; reg_wdata = d; eng_txn_ok = ok; eng_txn_done = dn;
    model_next();
    @(posedge clk); #1;
    model_commit();
    reg_wr = 0; eng_txn_ok = '0; eng_txn_done = '0;
    check_outputs();
  endtask

  task automatic rd(logic [4:0] a, string tag);
    reg_addr = a; #0.5;
    chk($sformatf("%s read addr %0d", tag, a), reg_rdata, model_read(a));
  endtask

  function automatic logic [4:0] ca(int p); return {4'(p), 1'b0}; endfunction
  function automatic logic [4:0] na(int p); return {4'(p), 1'b1}; endfunction

  initial begin
    #800000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    model_reset();
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    // R1: reset state on every register
    step(0, '0, '0, '0, '0);
    for (int a = 0; a < 32; a++) rd(5'(a), "R1");
    chk("R1 toggle vector", 16'(pipe_toggle), 16'h0);

    // R3: set, clear, both together (clear wins)
    step(1, ca(3), 16'h0002, '0, '0);
    chk("R3 toggle after set", 16'(pipe_toggle[3]), 16'h1);
    rd(ca(3), "R3");
    step(1, ca(3), 16'h0006, '0, '0);
    chk("R3 set and clear together", 16'(pipe_toggle[3]), 16'h0);

    // R4: flip only while BUF
    step(1, ca(4), 16'h0000, 10'h010, '0);
    chk("R4 no flip in NAK", 16'(pipe_toggle[4]), 16'h0);
    step(1, ca(3), 16'h0001, '0, '0);
    step(0, '0, '0, 10'h008, '0);
    chk("R4 flip in BUF", 16'(pipe_toggle[3]), 16'h1);

    // R5: locked write discarded, error sticky, W1C
    step(1, ca(3), 16'h0005, '0, '0);
    chk("R5 toggle kept", 16'(pipe_toggle[3]), 16'h1);
    chk("R5 err raised", 16'(pipe_lock_err[3]), 16'h1);
    step(1, ca(3), 16'h0201, '0, '0);
    chk("R5 err cleared", 16'(pipe_lock_err[3]), 16'h0);

    // R11: request set, cleared by BUF to NAK
    step(1, ca(3), 16'h0401, '0, '0);
    rd(ca(3), "R11");
    step(1, ca(3), 16'h0400, '0, '0);
    rd(ca(3), "R11");
    chk("R11 request cleared", reg_rdata & 16'h0400, 16'h0);

    // R6 / R7: unimplemented fields
    step(1, ca(0), 16'h00D0, '0, '0);
    rd(ca(0), "R6");
    chk("R6 pipe0 abc", 16'(pipe_auto_clr[0]), 16'h0);
    step(1, na(7), 16'h0033, '0, '0);
    rd(na(7), "R7");
    chk("R7 pipe7 count", reg_rdata, 16'h0);

    // R8: count down to done
    step(1, na(2), 16'h0003, '0, '0);
    step(1, ca(2), 16'h0040, '0, '0);
    for (int k = 0; k < 3; k++) step(0, '0, '0, '0, 10'h004);
    chk("R8 done at zero", 16'(pipe_cnt_done[2]), 16'h1);
    step(0, '0, '0, '0, 10'h004);
    rd(na(2), "R8");

    // R9: clear strobe and decrement in the same cycle
    step(1, ca(2), 16'h00C0, '0, 10'h004);
    step(0, '0, '0, '0, 10'h004);
    rd(na(2), "R9");
    step(1, ca(2), 16'h00C0, '0, 10'h004);
    rd(na(2), "R9");
    chk("R9 clear beats decrement", reg_rdata, 16'h0003);

    // R10: live busy
    eng_busy = 10'h2A5;
    rd(ca(5), "R10");
    rd(ca(2), "R10");

    // R12: out-of-range pipes
    step(1, ca(12), 16'hFFFF, '0, '0);
    rd(ca(12), "R12");
    rd(na(11), "R12");

    // Random traffic
    for (int n = 0; n < 4000; n++) begin
      int op = $urandom % 100;
      int p  = $urandom % 12;
      logic [15:0] d = 16'($urandom);
      logic [NP-1:0] ok = NP'($urandom);
      logic [NP-1:0] dn = NP'($urandom);
      eng_busy = NP'($urandom);
      if (op < 25)      step(1, ca(p), d & 16'h07F7, ok, dn);
      else if (op < 35) step(1, ca(p), {5'd0, d[10], 1'b0, 8'd0, d[0]} | 16'h0200, ok, dn);
      else if (op < 50) step(1, na(p), 16'($urandom % 6), ok, dn);
      else              step(0, '0, '0, ok, dn);
      rd(5'($urandom), "R12");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule